// File: doc/BRIEF.md
# Double-Buffered Byte SPI Controller

This block is a byte-wide serial peripheral interface controller that runs either as the clock-generating master or as a clocked slave. A single mode bit picks the role. Software talks to it through two register addresses. The data address takes transmit bytes into a holding buffer and returns the last received byte. The control/status address sets the mode and the shift rate, and reports the transfer flags.

The transmit buffer is kept apart from the shift register and has its own empty flag. A master can therefore queue the next byte while the current one is still shifting. On the serial side the block works in SPI mode 0 only. The clock idles low, data is sampled on the rising edge and changed on the falling edge, and bytes go MSB first. Every transfer is full duplex.

A finished byte lands in the receive buffer in the same cycle that the receive-full flag rises. If a byte completes while that flag is still set, the new byte is dropped and a sticky overflow flag is raised. Both flags clear only through a status read that sees receive-full set, followed by a data read.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: Control bit 0 selects the role: 1 is master and 0 is slave. Reset leaves the block in slave mode. In slave mode a data write starts nothing: `ss_n_o` stays 1 and `sck_o` stays 0.
- R2: In master mode with an idle shifter, a data write makes transmit-empty read 0 in the next cycle. In the cycle after that the byte moves into the shifter, transmit-empty reads 1 and `ss_n_o` goes low.
- R3: Every data write clears transmit-empty. A byte written while a transfer is running stays buffered, and transmit-empty stays 0, until the running transfer ends.
- R4: The master sends MSB first in mode 0. `sck_o` idles at 0, `mosi_o` changes only while `sck_o` is low, and `ss_n_o` stays low for the whole byte and returns high afterwards.
- R5: The transfer is full duplex. The master assembles the byte sampled from `miso_i` on its rising `sck_o` edges.
- R6: Control bits 2:1 hold a rate code r. Each `sck_o` phase lasts 4^r system clocks, so the period is 2, 8, 32 or 128 clocks. Receive-full rises exactly 16·4^r cycles after the byte enters the shifter.
- R7: When a byte completes, the receive buffer takes it in the same cycle that receive-full rises.
- R8: Receive-full clears only when a status read that sees it set is followed by a data read. A data read with no such status read before it leaves the flag set.
- R9: In slave mode, `sck_i` edges are ignored while `ss_n_i` is high. Under select, the slave receives `mosi_i` MSB first and returns the transmit-buffer byte MSB first on `miso_o`.
- R10: If a byte completes while receive-full is set, the receive buffer keeps its old byte, overflow (status bit 6) is set, and overflow clears through the same status-then-data sequence.
- R11: Status layout: bit 7 receive-full, bit 6 overflow, bit 5 transmit-empty, bits 2:1 rate, bit 0 mode, all other bits 0. The reset value is 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data, 1 = control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sck_o | output | 1 | Master serial clock out |
| mosi_o | output | 1 | Master serial data out |
| ss_n_o | output | 1 | Master slave-select out, active low |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave serial data in |
| ss_n_i | input | 1 | Slave select in, active low |
| miso_o | output | 1 | Slave serial data out |

## Verification
A wrong divider count or bit count in the master shows up directly as receive-full rising on the wrong cycle, so the bench measures that cycle exactly for every rate code. A shifter that loads or shifts at the wrong edge corrupts the byte captured on `mosi_o` or the byte read back from the receive buffer within one transfer. A broken flag state machine appears at the status port within one or two reads. Examples are an arming bit that never sets, overflow that overwrites the buffer, or a write that does not clear transmit-empty.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    localparam int ST_RXF   = 7;
    localparam int ST_OVF   = 6;
    localparam int ST_TXE   = 5;
    localparam int RATE_LSB = 1;
    localparam int MODE_BIT = 0;

    typedef enum logic {
        ADDR_DATA = 1'b0,
        ADDR_CTRL = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
    import spi_dbuf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              master_mode,
    output logic [RATE_W-1:0] rate_sel,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_byte,
    input  logic              tx_take,
    input  logic              rx_done,
    input  logic [DW-1:0]     rx_byte
);
    typedef struct packed {
        logic              mode;
        logic [RATE_W-1:0] rate;
        logic              txe;
        logic [DW-1:0]     txb;
        logic              rxf;
        logic              ovf;
        logic [DW-1:0]     rxb;
        logic              armed;
    } regs_t;

    regs_t q, d;
    logic rd_stat, rd_data, wr_data, wr_ctrl, clear_w, rxf_base;

    always_comb begin
        rd_stat  = bus_en && !bus_wr && bus_addr == ADDR_CTRL;
        rd_data  = bus_en && !bus_wr && bus_addr == ADDR_DATA;
        wr_data  = bus_en &&  bus_wr && bus_addr == ADDR_DATA;
        wr_ctrl  = bus_en &&  bus_wr && bus_addr == ADDR_CTRL;
        clear_w  = rd_data && q.armed;
        rxf_base = clear_w ? 1'b0 : q.rxf;

        d       = q;
        d.rxf   = rxf_base;
        d.ovf   = clear_w ? 1'b0 : q.ovf;
        if (rd_stat)      d.armed = q.rxf;
        else if (rd_data) d.armed = 1'b0;
        if (rx_done) begin
            if (rxf_base) d.ovf = 1'b1;
            else begin
                d.rxf = 1'b1;
                d.rxb = rx_byte;
            end
        end
        if (tx_take) d.txe = 1'b1;
        if (wr_data) begin
            d.txb = bus_wdata;
            d.txe = 1'b0;
        end
        if (wr_ctrl) begin
            d.mode = bus_wdata[MODE_BIT];
            d.rate = bus_wdata[RATE_LSB +: RATE_W];
        end

        bus_rdata = '0;
        if (bus_addr == ADDR_DATA) bus_rdata = q.rxb;
        else begin
            bus_rdata[ST_RXF]               = q.rxf;
            bus_rdata[ST_OVF]               = q.ovf;
            bus_rdata[ST_TXE]               = q.txe;
            bus_rdata[RATE_LSB +: RATE_W]   = q.rate;
            bus_rdata[MODE_BIT]             = q.mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.txe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign master_mode = q.mode;
    assign rate_sel    = q.rate;
    assign tx_valid    = !q.txe;
    assign tx_byte     = q.txb;

    // R8
    rxf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rxf) |-> $past(rd_data));
    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $past(q.rxf && rx_done));
    // R7
    rxb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.rxb) |-> ($past(rx_done) && q.rxf));
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
    parameter int DW     = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              tx_valid,
    input  logic [DW-1:0]     tx_byte,
    output logic              tx_take,
    output logic              done,
    output logic [DW-1:0]     rx_byte,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              ss_n_o,
    input  logic              miso_i
);
    localparam int CNT_W = 2 * ((1 << RATE_W) - 1);
    localparam int BW    = $clog2(DW);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [CNT_W-1:0] cnt;
        logic [BW-1:0]    bits;
        logic [DW-1:0]    shreg;
        logic             inbit;
    } mst_t;

    mst_t q, d;
    logic [CNT_W:0] lim_w;

    always_comb begin
        lim_w   = ({{CNT_W{1'b0}}, 1'b1} << (2 * rate_sel)) - 1'b1;
        d       = q;
        tx_take = 1'b0;
        done    = 1'b0;
        if (!q.busy) begin
            if (en && tx_valid) begin
                d.busy  = 1'b1;
                d.shreg = tx_byte;
                d.cnt   = '0;
                d.bits  = '0;
                d.sck   = 1'b0;
                tx_take = 1'b1;
            end
        end else if (q.cnt == lim_w[CNT_W-1:0]) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck   = 1'b1;
                d.inbit = miso_i;
            end else begin
                d.sck   = 1'b0;
                d.shreg = {q.shreg[DW-2:0], q.inbit};
                d.bits  = q.bits + 1'b1;
                if (q.bits == BW'(DW - 1)) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte = {q.shreg[DW-2:0], q.inbit};
    assign sck_o   = q.sck;
    assign mosi_o  = q.busy & q.shreg[DW-1];
    assign ss_n_o  = !q.busy;

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sck_o);
    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_dbuf_slave.sv
module spi_dbuf_slave #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] tx_byte,
    output logic          tx_take,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          ss_n_i,
    output logic          miso_o
);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        logic [2:0]    sck_s;
        logic [2:0]    ss_s;
        logic [1:0]    mo_s;
        logic          active;
        logic [BW-1:0] bits;
        logic [DW-1:0] shreg;
        logic          inbit;
    } slv_t;

    slv_t q, d;
    logic rise_w, fall_w, start_w;

    always_comb begin
        rise_w  =  q.sck_s[1] && !q.sck_s[2];
        fall_w  = !q.sck_s[1] &&  q.sck_s[2];
        start_w = !q.ss_s[1]  &&  q.ss_s[2];
        d       = q;
        d.sck_s = {q.sck_s[1:0], sck_i};
        d.ss_s  = {q.ss_s[1:0], ss_n_i};
        d.mo_s  = {q.mo_s[0], mosi_i};
        tx_take = 1'b0;
        done    = 1'b0;
        if (!en) begin
            d.active = 1'b0;
        end else if (start_w) begin
            d.active = 1'b1;
            d.bits   = '0;
            d.shreg  = tx_byte;
            tx_take  = 1'b1;
        end else if (q.ss_s[1]) begin
            d.active = 1'b0;
        end else if (q.active) begin
            if (rise_w) d.inbit = q.mo_s[1];
            if (fall_w) begin
                d.shreg = {q.shreg[DW-2:0], q.inbit};
                d.bits  = q.bits + 1'b1;
                if (q.bits == BW'(DW - 1)) begin
                    done    = 1'b1;
                    d.shreg = tx_byte;
                    tx_take = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ss_s <= '1;
        end else begin
            q <= d;
        end
    end

    assign rx_byte = {q.shreg[DW-2:0], q.inbit};
    assign miso_o  = q.active & q.shreg[DW-1];

    // R9
    slave_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (q.active && !q.ss_s[1]));
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl #(
    parameter int DW     = 8,
    parameter int RATE_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          ss_n_o,
    input  logic          miso_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          ss_n_i,
    output logic          miso_o
);
    logic              master_mode, tx_valid;
    logic [RATE_W-1:0] rate_sel;
    logic [DW-1:0]     tx_byte, m_rx, s_rx, rx_byte;
    logic              m_take, s_take, m_done, s_done;

    spi_dbuf_regs #(.DW(DW), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .master_mode(master_mode), .rate_sel(rate_sel), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_take(m_take | s_take),
        .rx_done(m_done | s_done), .rx_byte(rx_byte)
    );

    spi_dbuf_master #(.DW(DW), .RATE_W(RATE_W)) u_master (
        .clk(clk), .rst_n(rst_n), .en(master_mode), .rate_sel(rate_sel),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(m_take),
        .done(m_done), .rx_byte(m_rx), .sck_o(sck_o), .mosi_o(mosi_o),
        .ss_n_o(ss_n_o), .miso_i(miso_i)
    );

    spi_dbuf_slave #(.DW(DW)) u_slave (
        .clk(clk), .rst_n(rst_n), .en(!master_mode), .tx_byte(tx_byte),
        .tx_take(s_take), .done(s_done), .rx_byte(s_rx), .sck_i(sck_i),
        .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o)
    );

    assign rx_byte = master_mode ? m_rx : s_rx;

    // R1
    role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_done && s_done));
endmodule

// File: tb/test_spi_dbuf_ctrl.sv
module test_spi_dbuf_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_o, mosi_o, ss_n_o, miso_i, miso_o;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spi_dbuf_ctrl i_spi_dbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .miso_i(miso_i),
        .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o)
    );

    // bench-side mode-0 slave answering the master
    logic [7:0] sl_tx = 8'h00;
    logic [7:0] sl_rx = 8'h00;
    int falls = 0;
    int base  = 0;
    always @(negedge sck_o) falls <= falls + 1;
    always @(negedge ss_n_o) base <= falls;
    always @(posedge sck_o) sl_rx <= {sl_rx[6:0], mosi_o};
    assign miso_i = (falls - base < 8) ? sl_tx[7 - (falls - base)] : 1'b0;

    // rate code, master tx byte, slave reply byte
    localparam logic [23:0] VEC [0:3] = '{
        24'h00_A5_3C, 24'h01_81_7E, 24'h02_FF_00, 24'h03_12_ED
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] dat);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = dat;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] dat);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 dat = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    // polls status from the current negedge; k = cycles until receive-full
    task automatic poll_rxf(output int k, output logic [7:0] s0, output logic [7:0] s1,
                            output logic ss1, output logic [7:0] dat);
        k = 0;
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
        s0 = '0; s1 = '0; ss1 = 1'b1;
        forever begin
            #1;
            if (k == 0) s0 = bus_rdata;
            if (k == 1) begin s1 = bus_rdata; ss1 = ss_n_o; end
            if (bus_rdata[7]) break;
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        bus_addr = 1'b0;
        #1 dat = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic slv_xfer(input logic [7:0] mo, output logic [7:0] mi);
        @(negedge clk);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = mo[i];
            repeat (8) @(negedge clk);
            sck_i = 1'b1;
            mi[i] = miso_o;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s, s0, s1, dat, mi;
        logic ss1;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(1'b1, s);
        chk("R11 reset status", s, 8'h20);
        chk("R4 reset idle sck/ss", {sck_o, ss_n_o}, 2'b01);

        // R1 slave mode: a write starts nothing on the master pins
        wr(1'b0, 8'h3C);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ss_n_o !== 1'b1 || sck_o !== 1'b0) k = -1;
        end
        chk("R1 slave ignores write", k, 0);

        // R9 sck toggles while deselected are ignored
        for (int i = 0; i < 4; i++) begin
            mosi_i = 1'b1; repeat (6) @(negedge clk);
            sck_i = 1'b1;  repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        rd(1'b1, s);
        chk("R9 deselected no rx", s[7], 0);

        // R9 slave full duplex
        slv_xfer(8'hC3, mi);
        chk("R9 slave miso byte", mi, 8'h3C);
        rd(1'b0, dat);
        chk("R8 data read alone returns byte", dat, 8'hC3);
        rd(1'b1, s);
        chk("R8 rxf kept without status read", s[7], 1);
        rd(1'b0, dat);
        rd(1'b1, s);
        chk("R8 rxf cleared by sequence", s[7:6], 0);

        // R10 overflow
        slv_xfer(8'h5A, mi);
        slv_xfer(8'h99, mi);
        rd(1'b1, s);
        chk("R10 ovf and rxf set", s[7:6], 2'b11);
        rd(1'b0, dat);
        chk("R10 old byte kept", dat, 8'h5A);
        rd(1'b1, s);
        chk("R10 flags cleared", s[7:6], 0);

        // master vectors: R2 R3 R5 R6 R7
        foreach (VEC[v]) begin
            logic [7:0] r;
            r = VEC[v][23:16];
            sl_tx = VEC[v][7:0];
            wr(1'b1, (r << 1) | 8'h01);
            rd(1'b1, s);
            chk("R11 ctrl readback", s, 8'h21 | (r << 1));
            wr(1'b0, VEC[v][15:8]);
            poll_rxf(k, s0, s1, ss1, dat);
            chk("R3 write clears txe", s0[5], 0);
            chk("R2 txe set on load", s1[5], 1);
            chk("R2 ss low on load", ss1, 0);
            chk("R6 rxf cycle", k, 1 + 16 * (1 << (2 * r)));
            chk("R4 mosi byte", sl_rx, VEC[v][15:8]);
            chk("R5 R7 rx byte", dat, VEC[v][7:0]);
            rd(1'b1, s);
            chk("R8 rxf cleared", s[7], 0);
            chk("R4 idle after", {sck_o, ss_n_o}, 2'b01);
        end

        // R3 write during a transfer stays buffered
        wr(1'b1, 8'h01);
        sl_tx = 8'h00;
        wr(1'b0, 8'h11);
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h22);
        rd(1'b1, s);
        chk("R3 txe low while busy", s[5], 0);
        repeat (5) @(negedge clk);
        rd(1'b1, s);
        chk("R3 txe still low", s[5], 0);
        poll_rxf(k, s0, s1, ss1, dat);
        repeat (40) @(negedge clk);
        chk("R3 queued byte sent", sl_rx, 8'h22);
        rd(1'b1, s);
        chk("R3 txe set after", s[5], 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule